// File: doc/BRIEF.md
# Dual-Output Clock Post-Divider with Glitch-Free Stop

This block takes a fast source clock and produces two related output clocks. The primary output runs at the source frequency divided by a power of two between 2 and 64, chosen by a 3-bit ratio code. The secondary output either matches the primary or runs at half its rate, chosen by a one-bit select. When the secondary runs at half rate, every one of its rising edges lands on a rising edge of the primary.

Each output has its own active-low stop input. A stop is synchronized and then applied only at that output's own period boundary, so the output parks low or restarts without a shortened pulse. The divider counters keep running while an output is parked, so a restarted output falls back into phase with the other. Ratio and select changes are held back until the end of a full secondary period, so a reconfiguration never produces a partial cycle. An asynchronous active-low master reset forces both outputs low at once. It does not wait for any pulse to finish.

Top module: `clk_postdiv`

## Requirements
- R1: While `rst_n` is low both outputs are low. Asserting `rst_n` drives both outputs low at once, with no source edge needed.
- R2: The primary output period is R source cycles: high for R/2 cycles, then low for R/2 cycles. R is set by `na_code`: 000 gives 2, 100 gives 4, 010 gives 8, 110 gives 16, 001 gives 32, 101 gives 64. The reset default code is 010.
- R3: The reserved codes 011 and 111 give a ratio of 64.
- R4: With `nb_half` = 0 and both outputs running, the secondary output is identical to the primary, cycle for cycle.
- R5: With `nb_half` = 1 the secondary period is 2R cycles with a 50% duty cycle. Every secondary rising edge coincides with a primary rising edge whenever the primary is running.
- R6: A low level on a stop input parks that output low within two of its own periods. No high pulse is ever shortened, and no low pulse is shorter than a normal half period.
- R7: Releasing a stop restarts that output within two of its own periods, and the first high pulse has full width. After any stop and release, the secondary rising edges stay coincident with primary rising edges.
- R8: The two stop inputs are independent. Parking one output leaves the other running at its configured rate.
- R9: A change of `na_code` or `nb_half` takes effect only at the end of a full secondary period. During the change every high pulse has either the old width or the new width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| na_code | input | 3 | Primary divide-ratio code |
| nb_half | input | 1 | 0: secondary equals primary; 1: secondary at half rate |
| stop_a_n | input | 1 | Active-low stop for the primary output |
| stop_b_n | input | 1 | Active-low stop for the secondary output |
| clk_a | output | 1 | Primary divided clock |
| clk_b | output | 1 | Secondary divided clock |

## Verification
Both outputs come from flops, so every level change appears right after a source rising edge. The bench samples outputs and drives inputs only around falling edges. A stop or release reaches the pins after two synchronizer edges, plus the wait for the output's own period boundary. The bench therefore allows two full output periods before it checks that an output is parked, and it looks for a restart inside the same window. A code change waits for the current secondary period to end. The bench lets up to 300 cycles pass under a monitor that accepts only old-width or new-width pulses. It then measures rising-edge counts over windows that are whole multiples of the secondary period, so the expected counts are exact.

// File: rtl/cpd_pkg.sv
`timescale 1ns/1ps
package cpd_pkg;
  localparam int CODE_W  = 3;
  localparam int LOG_MAX = 6;
  localparam int LOG_W   = $clog2(LOG_MAX + 1);
  localparam int CNT_W   = LOG_MAX;
  localparam int NCH     = 2;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [LOG_W-1:0]  log_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  localparam logic [CNT_W:0] ONE_W = {{CNT_W{1'b0}}, 1'b1};

  // Ratio code is the bit-reversed log2 of (ratio/2); reserved values clamp.
  function automatic log_t code_to_log(input code_t c);
    code_t r;
    for (int i = 0; i < CODE_W; i++) r[i] = c[CODE_W-1-i];
    if (int'(r) > LOG_MAX - 1) r = code_t'(LOG_MAX - 1);
    return log_t'(int'(r) + 1);
  endfunction

  // Last count value of one primary period (ratio - 1).
  function automatic cnt_t last_count(input log_t lg);
    return cnt_t'((ONE_W << lg) - ONE_W);
  endfunction

  // Count at which the primary output falls (ratio / 2).
  function automatic cnt_t half_count(input log_t lg);
    return cnt_t'(ONE_W << (lg - log_t'(1)));
  endfunction
endpackage

// File: rtl/cpd_sync.sv
`timescale 1ns/1ps
module cpd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-2:0], d};
  end

  assign q = shift_q[STAGES-1];
endmodule

// File: rtl/cpd_counter.sv
`timescale 1ns/1ps
module cpd_counter import cpd_pkg::*; #(
  parameter code_t DEF_CODE = 3'b010
) (
  input  logic  clk,
  input  logic  rst_n,
  input  code_t na_code,
  input  logic  nb_half,
  output logic  wrap_pri,
  output logic  wrap_sec,
  output logic  lvl_pri,
  output logic  lvl_sec
);
  cnt_t cnt_q, cnt_d;
  log_t log_q, log_d;
  logic nb_q, nb_d;
  logic ph_q, ph_d;

  assign wrap_pri = (cnt_q == last_count(log_q));
  assign wrap_sec = wrap_pri & (~nb_q | ph_q);

  always_comb begin
    log_d = wrap_sec ? code_to_log(na_code) : log_q;
    nb_d  = wrap_sec ? nb_half : nb_q;
    cnt_d = wrap_pri ? '0 : cnt_q + cnt_t'(1);
    if (wrap_sec)      ph_d = 1'b0;
    else if (wrap_pri) ph_d = ~ph_q;
    else               ph_d = ph_q;
    lvl_pri = (cnt_d < half_count(log_d));
    lvl_sec = nb_d ? ~ph_d : lvl_pri;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      log_q <= code_to_log(DEF_CODE);
      nb_q  <= 1'b0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      log_q <= log_d;
      nb_q  <= nb_d;
      ph_q  <= ph_d;
    end
  end
endmodule

// File: rtl/cpd_gate.sv
`timescale 1ns/1ps
module cpd_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic bound,
  input  logic run,
  input  logic lvl,
  output logic en_q,
  output logic out_q
);
  logic en_d;

  assign en_d = bound ? run : en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      out_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      out_q <= en_d & lvl;
    end
  end
endmodule

// File: rtl/clk_postdiv.sv
`timescale 1ns/1ps
module clk_postdiv import cpd_pkg::*; #(
  parameter int    SYNC_STAGES = 2,
  parameter code_t DEF_CODE    = 3'b010
) (
  input  logic       clk_src,
  input  logic       rst_n,
  input  logic [2:0] na_code,
  input  logic       nb_half,
  input  logic       stop_a_n,
  input  logic       stop_b_n,
  output logic       clk_a,
  output logic       clk_b
);
  logic [NCH-1:0] stop_vec, run_vec, bound_vec, lvl_vec, en_vec, out_vec;
  logic wrap_a, wrap_b, en_a, en_b;
  logic lvl_pri, lvl_sec;

  cpd_counter #(.DEF_CODE(DEF_CODE)) u_cnt (
    .clk      (clk_src),
    .rst_n    (rst_n),
    .na_code  (na_code),
    .nb_half  (nb_half),
    .wrap_pri (wrap_a),
    .wrap_sec (wrap_b),
    .lvl_pri  (lvl_pri),
    .lvl_sec  (lvl_sec)
  );

  assign stop_vec  = {stop_b_n, stop_a_n};
  assign bound_vec = {wrap_b, wrap_a};
  assign lvl_vec   = {lvl_sec, lvl_pri};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    cpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk_src),
      .rst_n (rst_n),
      .d     (stop_vec[ch]),
      .q     (run_vec[ch])
    );
    cpd_gate u_gate (
      .clk   (clk_src),
      .rst_n (rst_n),
      .bound (bound_vec[ch]),
      .run   (run_vec[ch]),
      .lvl   (lvl_vec[ch]),
      .en_q  (en_vec[ch]),
      .out_q (out_vec[ch])
    );
  end

  assign en_a  = en_vec[0];
  assign en_b  = en_vec[1];
  assign clk_a = out_vec[0];
  assign clk_b = out_vec[1];
endmodule

// File: rtl/cpd_checker.sv
`timescale 1ns/1ps
module cpd_checker #(
  parameter int STOP_LIMIT = 300
) (
  input logic clk,
  input logic rst_n,
  input logic stop_a_n,
  input logic clk_a,
  input logic clk_b,
  input logic wrap_a,
  input logic wrap_b,
  input logic en_a,
  input logic en_b
);
  int unsigned stop_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     stop_cnt <= 0;
    else if (stop_a_n)              stop_cnt <= 0;
    else if (stop_cnt < STOP_LIMIT) stop_cnt <= stop_cnt + 1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_low_R1: assert (!clk_a && !clk_b)
        else $error("outputs not low during reset");
    end
  end

  assert_pri_rise_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_a) |-> $past(wrap_a))
    else $error("primary rose off its boundary");

  assert_sec_rise_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_b) |-> $past(wrap_b))
    else $error("secondary rose off its boundary");

  assert_coincident_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(clk_b) && en_a) |-> $rose(clk_a))
    else $error("secondary edge not coincident with primary");

  assert_enable_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(en_a) || $fell(en_a)) |-> $past(wrap_a))
    else $error("primary enable changed off boundary");

  assert_sec_enable_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(en_b) || $fell(en_b)) |-> $past(wrap_b))
    else $error("secondary enable changed off boundary");

  assert_parked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_cnt == STOP_LIMIT) |-> !clk_a)
    else $error("primary not parked after long stop");
endmodule

bind clk_postdiv cpd_checker u_chk (
  .clk      (clk_src),
  .rst_n    (rst_n),
  .stop_a_n (stop_a_n),
  .clk_a    (clk_a),
  .clk_b    (clk_b),
  .wrap_a   (wrap_a),
  .wrap_b   (wrap_b),
  .en_a     (en_a),
  .en_b     (en_b)
);

// File: tb/test_clk_postdiv.sv
`timescale 1ns/1ps
module test_clk_postdiv;
  logic       clk_src = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] na_code = 3'b010;
  logic       nb_half = 1'b0;
  logic       stop_a_n = 1'b1;
  logic       stop_b_n = 1'b1;
  wire        clk_a, clk_b;

  clk_postdiv i_clk_postdiv (
    .clk_src(clk_src), .rst_n(rst_n), .na_code(na_code), .nb_half(nb_half),
    .stop_a_n(stop_a_n), .stop_b_n(stop_b_n), .clk_a(clk_a), .clk_b(clk_b));

  always #2.5 clk_src = ~clk_src;

  int n_tests = 0, n_fail = 0;
  logic [2:0] cur_code = 3'b010;
  bit cur_nb = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int ratio_of(input logic [2:0] c);
    case (c)
      3'b000: return 2;
      3'b100: return 4;
      3'b010: return 8;
      3'b110: return 16;
      3'b001: return 32;
      3'b101: return 64;
      default: return 64;
    endcase
  endfunction

  // Pulse-width monitor: high runs must equal one of two allowed widths,
  // low runs must be at least the smaller one.
  bit mon_on = 0, skip_a = 1, skip_b = 1;
  int ha0, ha1, hb0, hb1, err_a, err_b, run_a, run_b;
  logic pa = 0, pb = 0;

  always @(negedge clk_src) begin
    if (!mon_on) begin
      skip_a = 1; skip_b = 1; run_a = 0; run_b = 0;
    end else begin
      if (clk_a === pa) run_a++;
      else begin
        if (!skip_a) begin
          if (pa) begin if (run_a != ha0 && run_a != ha1) err_a++; end
          else if (run_a < ((ha0 < ha1) ? ha0 : ha1)) err_a++;
        end
        skip_a = 0; run_a = 1;
      end
      if (clk_b === pb) run_b++;
      else begin
        if (!skip_b) begin
          if (pb) begin if (run_b != hb0 && run_b != hb1) err_b++; end
          else if (run_b < ((hb0 < hb1) ? hb0 : hb1)) err_b++;
        end
        skip_b = 0; run_b = 1;
      end
    end
    pa = clk_a; pb = clk_b;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk_src);
  endtask

  task automatic set_mon(input int a0, input int a1, input int b0, input int b1);
    @(negedge clk_src); #1;
    ha0 = a0; ha1 = a1; hb0 = b0; hb1 = b1;
    skip_a = 1; skip_b = 1; err_a = 0; err_b = 0; mon_on = 1;
  endtask

  // Reconfigure with a monitor that accepts only old or new pulse widths (R9).
  task automatic reconfig(input logic [2:0] code, input bit nb);
    int oa, na, ob, nbw;
    oa = ratio_of(cur_code) / 2; na = ratio_of(code) / 2;
    ob = cur_nb ? 2 * oa : oa;  nbw = nb ? 2 * na : na;
    set_mon(oa, na, ob, nbw);
    na_code = code; nb_half = nb;
    step(300); #1;
    chk(err_a == 0, "R9", "primary partial pulse on reconfig", err_a, 0);
    chk(err_b == 0, "R9", "secondary partial pulse on reconfig", err_b, 0);
    cur_code = code; cur_nb = nb;
  endtask

  task automatic measure(input string ra, input string rb);
    int r, hb, n, rises_a, rises_b, mism;
    logic la, lb;
    r = ratio_of(cur_code); hb = cur_nb ? r : r / 2;
    set_mon(r / 2, r / 2, hb, hb);
    n = 8 * r; rises_a = 0; rises_b = 0; mism = 0;
    @(negedge clk_src); la = clk_a; lb = clk_b;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_src);
      if (clk_a && !la) rises_a++;
      if (clk_b && !lb) rises_b++;
      if (!cur_nb && clk_a !== clk_b) mism++;
      if (cur_nb && clk_b && !lb && !(clk_a && !la)) mism++;
      la = clk_a; lb = clk_b;
    end
    #1;
    chk(rises_a == n / r, ra, "primary rising edges", rises_a, n / r);
    chk(err_a == 0, ra, "primary pulse widths", err_a, 0);
    chk(rises_b == n / (2 * hb), rb, "secondary rising edges", rises_b, n / (2 * hb));
    chk(err_b == 0, rb, "secondary pulse widths", err_b, 0);
    chk(mism == 0, rb, "secondary alignment to primary", mism, 0);
  endtask

  // Park and release one output; per is that output's period in source cycles.
  task automatic stop_chan(input bit b, input int per);
    int highs, other_rises, waited;
    bit seen;
    logic lo;
    @(negedge clk_src); #1;
    if (b) stop_b_n = 0; else stop_a_n = 0;
    step(2 * per);
    highs = 0; other_rises = 0; lo = b ? clk_a : clk_b;
    for (int i = 0; i < 3 * per; i++) begin
      @(negedge clk_src);
      if ((b ? clk_b : clk_a) == 1'b1) highs++;
      if ((b ? clk_a : clk_b) && !lo) other_rises++;
      lo = b ? clk_a : clk_b;
    end
    chk(highs == 0, "R6", b ? "secondary parked low" : "primary parked low", highs, 0);
    chk(other_rises > 0, "R8", "other output kept running", other_rises, 1);
    @(negedge clk_src); #1;
    if (b) stop_b_n = 1; else stop_a_n = 1;
    seen = 0; waited = 0;
    for (int i = 0; i < 2 * per && !seen; i++) begin
      @(negedge clk_src);
      waited++;
      if ((b ? clk_b : clk_a) == 1'b1) seen = 1;
    end
    chk(seen, "R7", b ? "secondary restart latency" : "primary restart latency",
        waited, 2 * per);
  endtask

  task automatic runt_check(input string req);
    #1;
    chk(err_a == 0, req, "primary shortened pulse around stop", err_a, 0);
    chk(err_b == 0, req, "secondary shortened pulse around stop", err_b, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    step(4);
    chk(clk_a == 0 && clk_b == 0, "R1", "outputs low in reset", {clk_b, clk_a}, 0);
    @(negedge clk_src); #1 rst_n = 1;
    step(40);
    measure("R2", "R4");

    // R9 then R5: switch secondary to half rate
    reconfig(3'b010, 1'b1);
    measure("R2", "R5");

    // R6/R7/R8: stop and restart each output under the runt monitor
    set_mon(4, 4, 8, 8);
    stop_chan(1'b0, 8);
    stop_chan(1'b1, 16);
    runt_check("R6");
    measure("R7", "R7");

    // both stopped and released together
    @(negedge clk_src); #1 stop_a_n = 0; stop_b_n = 0;
    step(64);
    chk(clk_a == 0 && clk_b == 0, "R6", "both parked", {clk_b, clk_a}, 0);
    @(negedge clk_src); #1 stop_a_n = 1; stop_b_n = 1;
    step(64);
    measure("R7", "R7");

    // divide by 2, equal rate
    reconfig(3'b000, 1'b0);
    measure("R2", "R4");
    set_mon(1, 1, 1, 1);
    stop_chan(1'b0, 2);
    stop_chan(1'b1, 2);
    runt_check("R7");

    // reserved codes
    reconfig(3'b011, 1'b0);
    measure("R3", "R4");
    reconfig(3'b111, 1'b1);
    measure("R3", "R5");

    // R1: asynchronous reset while primary high
    reconfig(3'b100, 1'b0);
    do @(negedge clk_src); while (clk_a !== 1'b1);
    #1 rst_n = 0;
    #0.5;
    chk(clk_a == 0 && clk_b == 0, "R1", "async reset forces low", {clk_b, clk_a}, 0);
    mon_on = 0;
    step(3);
    @(negedge clk_src); #1 rst_n = 1;
    cur_code = 3'b010; cur_nb = 0;
    na_code = 3'b010; nb_half = 0;
    step(40);
    measure("R2", "R4");

    // random configurations and stop pulses
    for (int it = 0; it < 16; it++) begin
      logic [2:0] c;
      bit nb;
      int len;
      c = 3'($urandom % 8);
      nb = 1'($urandom % 2);
      reconfig(c, nb);
      measure((c[1:0] == 2'b11) ? "R3" : "R2", nb ? "R5" : "R4");
      len = 1 + int'($urandom % 20);
      @(negedge clk_src); #1 stop_a_n = 0;
      step(len);
      #1 stop_b_n = 0;
      step(len);
      #1 stop_a_n = 1;
      step(3);
      #1 stop_b_n = 1;
      step(300);
      runt_check("R6");
      measure("R7", "R7");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_src);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule